// File: doc/BRIEF.md
# Host-to-Processor Request Mailbox

This block is a small shared buffer that carries requests from a host to an embedded acquisition processor and carries the answers back. The host sees three byte-wide registers: a pointer, a data port and a status register. The host loads the pointer, then writes a request through the data port. A request is a command byte, then a message-ID byte, then any payload bytes, all starting at offset 0. The host then raises the busy flag in the status register. The pointer advances by one on every data-port access.

The processor sees a request line and has direct addressed access to the same buffer. It reads the request and writes its answer over it from offset 0: the command byte and the message-ID byte echoed, then the data. It then pulses a one-cycle done strobe to drop the flag. The host polls the flag, reloads the pointer with 0 and streams the answer out through the same data port. The buffer holds `DEPTH` bytes, 128 by default.

The flag is held by a two-state machine. `ST_IDLE` moves to `ST_BUSY` on transition `T_POST`, which is a host status write with both the busy and load-enable bits set. `ST_BUSY` returns to `ST_IDLE` on transition `T_DONE`, which is a processor done strobe. It also returns on transition `T_CANCEL`, which is a host status write with load-enable set and busy clear. A status write without load-enable leaves the state where it is.

Top module: `hmbx_mailbox`

## Requirements
- R1: After reset the busy flag is 0, `proc_req` is 0 and the pointer is 0.
- R2: A write to the pointer register (select code 0) loads the pointer with the written value modulo DEPTH. A read of the pointer register returns the current pointer, zero-extended.
- R3: A write to the data register (select code 1) stores the byte at the pointer. A read of the data register returns the byte at the pointer. Either access then moves the pointer up by one.
- R4: The pointer wraps from DEPTH-1 to 0. Reads beyond the written region return whatever the buffer holds.
- R5: A write to the status register (select code 2) with bit 0 (busy) = 1 and bit 1 (load-enable) = 1 sets the busy flag (`T_POST`). `proc_req` is 1 from the next cycle on.
- R6: A status write with load-enable = 0 does not change the busy flag, whatever value bit 0 carries.
- R7: A status write with load-enable = 1 and busy = 0 clears the flag (`T_CANCEL`).
- R8: A one-cycle `proc_done` pulse clears the busy flag (`T_DONE`). In `ST_IDLE` the pulse has no effect.
- R9: When a host post and `proc_done` arrive in the same cycle, the flag ends up set.
- R10: A status read returns the busy flag in bit 0. Load-enable (bit 1) and all other bits read as 0.
- R11: The processor port reads and writes the same storage as the host data port. Request bytes written by the host appear at `proc_addr` offsets 0, 1, 2 and so on. Bytes written by the processor are read back by the host from offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe (advances pointer on data reads) |
| host_sel | input | 2 | Register select: 0 pointer, 1 data, 2 status |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, combinational from select and pointer |
| proc_addr | input | AW | Processor buffer address |
| proc_we | input | 1 | Processor buffer write strobe |
| proc_wdata | input | DW | Processor write data |
| proc_rdata | output | DW | Processor read data at proc_addr |
| proc_done | input | 1 | One-cycle strobe that clears the busy flag |
| proc_req | output | 1 | Busy flag: a request is pending |

## Verification
The bench writes status values that carry only one of the two flag bits. A design that ignores the load-enable gate would set or clear the flag on those writes. It drives a host post and a done strobe in the same cycle. A design with the wrong priority would lose the new request. It streams bytes across the top of the buffer. A design that saturates or misaddresses the pointer would leave the third byte at the wrong offset. It also pulses done while idle, and reloads the pointer with a value wider than the buffer to exercise the modulo load.

// File: rtl/hmbx_pkg.sv
package hmbx_pkg;
    typedef enum logic [1:0] {
        REG_PTR  = 2'd0,
        REG_DATA = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_t;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_LOAD_BIT = 1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } flag_state_t;
endpackage

// File: rtl/hmbx_ptr.sv
module hmbx_ptr #(
    parameter int DEPTH = 128,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load) begin
            ptr_q <= load_val;
        end else if (step) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/hmbx_ram.sv
module hmbx_ram #(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] h_addr,
    input  logic          h_we,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    input  logic [AW-1:0] p_addr,
    input  logic          p_we,
    input  logic [DW-1:0] p_wdata,
    output logic [DW-1:0] p_rdata
);
    logic [DW-1:0] mem [DEPTH];

    // host write placed last: it wins a same-address collision
    always_ff @(posedge clk) begin
        if (p_we) begin
            mem[p_addr] <= p_wdata;
        end
        if (h_we) begin
            mem[h_addr] <= h_wdata;
        end
    end

    assign h_rdata = mem[h_addr];
    assign p_rdata = mem[p_addr];
endmodule

// File: rtl/hmbx_flag_fsm.sv
module hmbx_flag_fsm
    import hmbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stat_wr,
    input  logic wr_busy,
    input  logic wr_load,
    input  logic done,
    output logic busy
);
    flag_state_t state_q, state_d;

    logic t_post, t_cancel;

    always_comb begin
        t_post   = stat_wr && wr_load && wr_busy;
        t_cancel = stat_wr && wr_load && !wr_busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (t_post) begin
                    state_d = ST_BUSY;
                end
            end
            ST_BUSY: begin
                if (t_post) begin
                    state_d = ST_BUSY;
                end else if (t_cancel || done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == ST_BUSY);
    end
endmodule

// File: rtl/hmbx_mailbox.sv
module hmbx_mailbox
    import hmbx_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic          host_re,
    input  logic [1:0]    host_sel,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    input  logic [AW-1:0] proc_addr,
    input  logic          proc_we,
    input  logic [DW-1:0] proc_wdata,
    output logic [DW-1:0] proc_rdata,
    input  logic          proc_done,
    output logic          proc_req
);
    logic [AW-1:0] ptr_q;
    logic [DW-1:0] buf_rdata;
    logic          sel_ptr, sel_data, sel_stat;
    logic          busy;

    always_comb begin
        sel_ptr  = (host_sel == REG_PTR);
        sel_data = (host_sel == REG_DATA);
        sel_stat = (host_sel == REG_STAT);
    end

    hmbx_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (host_we && sel_ptr),
        .load_val (host_wdata[AW-1:0]),
        .step     ((host_we || host_re) && sel_data),
        .ptr      (ptr_q)
    );

    hmbx_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
        .clk     (clk),
        .h_addr  (ptr_q),
        .h_we    (host_we && sel_data),
        .h_wdata (host_wdata),
        .h_rdata (buf_rdata),
        .p_addr  (proc_addr),
        .p_we    (proc_we),
        .p_wdata (proc_wdata),
        .p_rdata (proc_rdata)
    );

    hmbx_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_wr (host_we && sel_stat),
        .wr_busy (host_wdata[STAT_BUSY_BIT]),
        .wr_load (host_wdata[STAT_LOAD_BIT]),
        .done    (proc_done),
        .busy    (busy)
    );

    always_comb begin
        host_rdata = '0;
        unique case (1'b1)
            sel_ptr:  host_rdata[AW-1:0] = ptr_q;
            sel_data: host_rdata = buf_rdata;
            sel_stat: host_rdata[STAT_BUSY_BIT] = busy;
            default:  host_rdata = '0;
        endcase
    end

    assign proc_req = busy;
endmodule

// File: rtl/hmbx_mailbox_chk.sv
module hmbx_mailbox_chk
    import hmbx_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_we,
    input logic          host_re,
    input logic [1:0]    host_sel,
    input logic [DW-1:0] host_wdata,
    input logic [DW-1:0] host_rdata,
    input logic          proc_done,
    input logic          proc_req,
    input logic [AW-1:0] ptr
);
    logic stat_wr;
    assign stat_wr = host_we && (host_sel == REG_STAT);

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !proc_req && ptr == '0); // R1

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && host_sel == REG_PTR |=> ptr == $past(host_wdata[AW-1:0])); // R2

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we || host_re) && host_sel == REG_DATA |=> ptr == AW'($past(ptr) + 1'b1)); // R4

    AST_POST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && host_wdata[1] && host_wdata[0] |=> proc_req); // R5

    AST_NO_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && !host_wdata[1] && !proc_done |=> $stable(proc_req)); // R6

    AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr && host_wdata[1] && !host_wdata[0] |=> !proc_req); // R7

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        proc_done && !(stat_wr && host_wdata[1]) |=> !proc_req); // R8

    AST_LOAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_sel == REG_STAT |-> host_rdata[1] == 1'b0 && host_rdata[0] == proc_req); // R10
endmodule

bind hmbx_mailbox hmbx_mailbox_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .proc_done  (proc_done),
    .proc_req   (proc_req),
    .ptr        (ptr_q)
);

// File: tb/hmbx_mailbox_tb.sv
module hmbx_mailbox_tb;
    localparam int DEPTH = 128;
    localparam int DW = 8;
    localparam int AW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_we = 1'b0;
    logic          host_re = 1'b0;
    logic [1:0]    host_sel = 2'd3;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] proc_addr = '0;
    logic          proc_we = 1'b0;
    logic [DW-1:0] proc_wdata = '0;
    logic [DW-1:0] proc_rdata;
    logic          proc_done = 1'b0;
    logic          proc_req;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hmbx_mailbox #(.DEPTH(DEPTH), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_re(host_re), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .proc_addr(proc_addr), .proc_we(proc_we), .proc_wdata(proc_wdata),
        .proc_rdata(proc_rdata), .proc_done(proc_done), .proc_req(proc_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0; host_sel = 2'd3;
    endtask

    task automatic host_rd(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        host_re = 1'b1; host_sel = sel;
        #1 d = host_rdata;
        @(posedge clk);
        @(negedge clk);
        host_re = 1'b0; host_sel = 2'd3;
    endtask

    task automatic proc_rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        proc_addr = a;
        #1 d = proc_rdata;
    endtask

    task automatic proc_wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        proc_addr = a; proc_we = 1'b1; proc_wdata = d;
        @(posedge clk);
        @(negedge clk);
        proc_we = 1'b0;
    endtask

    task automatic proc_pulse_done();
        @(negedge clk);
        proc_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        proc_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        host_rd(2'd2, v); chk("R1 status", v, 8'h00);
        host_rd(2'd0, v); chk("R1 pointer", v, 8'h00);
        chk("R1 proc_req", {7'd0, proc_req}, 8'h00);
    endtask

    task automatic t_pointer();
        logic [7:0] v;
        host_wr(2'd0, 8'h85);
        host_rd(2'd0, v); chk("R2 modulo load", v, 8'h05);
        host_wr(2'd0, 8'h2A);
        host_rd(2'd0, v); chk("R2 load", v, 8'h2A);
    endtask

    task automatic t_request();
        logic [7:0] v;
        logic [7:0] req [4] = '{8'h3C, 8'h07, 8'hA1, 8'hA2};
        host_wr(2'd0, 8'h00);
        for (int i = 0; i < 4; i++) host_wr(2'd1, req[i]);
        host_rd(2'd0, v); chk("R3 pointer after writes", v, 8'h04);
        for (int i = 0; i < 4; i++) begin
            proc_rd(AW'(i), v); chk("R11 proc sees request", v, req[i]);
        end
        host_wr(2'd2, 8'h03);
        chk("R5 post sets proc_req", {7'd0, proc_req}, 8'h01);
        host_rd(2'd2, v); chk("R10 status read", v, 8'h01);
        host_wr(2'd2, 8'h00);
        chk("R6 no load keeps busy", {7'd0, proc_req}, 8'h01);
        proc_wr(0, 8'h3C); proc_wr(1, 8'h07); proc_wr(2, 8'h5E);
        proc_pulse_done();
        chk("R8 done clears", {7'd0, proc_req}, 8'h00);
        host_wr(2'd0, 8'h00);
        host_rd(2'd1, v); chk("R11 echo cmd", v, 8'h3C);
        host_rd(2'd1, v); chk("R11 echo id", v, 8'h07);
        host_rd(2'd1, v); chk("R3 response data", v, 8'h5E);
        host_rd(2'd1, v); chk("R4 read past region", v, 8'hA2);
        host_rd(2'd0, v); chk("R3 pointer after reads", v, 8'h04);
    endtask

    task automatic t_idle_strobes();
        proc_pulse_done();
        chk("R8 done ignored when idle", {7'd0, proc_req}, 8'h00);
        host_wr(2'd2, 8'h01);
        chk("R6 busy without load ignored", {7'd0, proc_req}, 8'h00);
    endtask

    task automatic t_cancel();
        logic [7:0] v;
        host_wr(2'd2, 8'h03);
        chk("R5 post", {7'd0, proc_req}, 8'h01);
        host_wr(2'd2, 8'h02);
        chk("R7 cancel", {7'd0, proc_req}, 8'h00);
        host_rd(2'd2, v); chk("R10 status after cancel", v, 8'h00);
    endtask

    task automatic t_race();
        @(negedge clk);
        host_we = 1'b1; host_sel = 2'd2; host_wdata = 8'h03; proc_done = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_we = 1'b0; host_sel = 2'd3; proc_done = 1'b0;
        chk("R9 post beats done", {7'd0, proc_req}, 8'h01);
        host_wr(2'd2, 8'h02);
    endtask

    task automatic t_wrap();
        logic [7:0] v;
        host_wr(2'd0, 8'd126);
        host_wr(2'd1, 8'h11); host_wr(2'd1, 8'h22); host_wr(2'd1, 8'h33);
        host_rd(2'd0, v); chk("R4 pointer wrapped", v, 8'h01);
        proc_rd(0, v); chk("R4 byte at offset 0", v, 8'h33);
        proc_rd(AW'(127), v); chk("R4 byte at top", v, 8'h22);
        host_wr(2'd0, 8'd127);
        host_rd(2'd1, v); chk("R4 read top", v, 8'h22);
        host_rd(2'd1, v); chk("R4 read after wrap", v, 8'h33);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pointer();
        t_request();
        t_idle_strobes();
        t_cancel();
        t_race();
        t_wrap();
        repeat (2) @(posedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule